// File: doc/BRIEF.md
# Montgomery Ladder Point-Multiply Sequencer

This block drives an x-only scalar multiplication kP over GF(2^m) by the Montgomery ladder in projective coordinates. It owns five working registers: two coordinates for each of the two ladder points (A and B) and one scratch register. It does no field arithmetic of its own. Each step is sent as a request (operand values on two buses, an operation code and the physical destination) to an external binary-field ALU. The ALU returns its result with a one-cycle done strobe. When the last key bit has been processed, A holds kP as the pair (x_out, z_out). The affine x is their ratio, and forming it is left to the caller.

The operation stream is the same for every key. A fixed microprogram runs an initialisation phase. It then runs one point addition and one point doubling per key bit, from the most significant bit down. The current key bit only exchanges the roles of the A and B registers on every read and write. The starting state (point at infinity in A, the generator in B) is built from squarings and additions of the generator. No preset hardware is used for it.

Top module: `ml_ladder_seq`

## Requirements
- R1: In the cycle after reset is released, alu_req, done, x_out and z_out are all 0.
- R2: A start accepted while idle or done issues five initialisation requests in this order: xB←g², zB←g², zA←xB+zB, zB←g+zA, xA←g². Operation codes are add=0, multiply=1, square of operand a=2, square of operand b=3. Destination codes are xA=0, xB=1, zA=2, zB=3, scratch=4. An operand that a square does not use carries the A-side register.
- R3: Each key bit starts with a seven-request addition: xB←xB·zA, zB←xA·zB, S←xB+zB, xB←xB·zB, zB←S², S←g·zB, xB←xB+S.
- R4: The addition is followed by a six-request doubling: xA←xA², zA←zA², S←c·zA, zA←xA·zA, xA←xA+S, xA←xA².
- R5: Key bits are used from index m−1 down to 0. A run issues exactly 5+13·m requests.
- R6: While key bit i is 1 during its iteration, every A reference (operand select and destination, x and z) becomes the B register and the reverse. The constants g and c and the scratch register are not swapped.
- R7: alu_req stays high with alu_a, alu_b, alu_op and alu_dst unchanged until alu_done. On alu_done the destination register takes alu_res.
- R8: After the index-0 iteration, done is high and alu_req is low. done, x_out and z_out hold until the next start.
- R9: The result is the ladder point kP. For k=0, z_out=0. For k=1, x_out = g·z_out with z_out nonzero. For k=2, x_out·g² = z_out·(g⁴+c²).
- R10: A start pulse while a run is in progress has no effect on the request stream or the result.
- R11: A start while done begins a new run from the initialisation step, with the key index back at m−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication (ignored while running) |
| key | input | M | Scalar k, held stable during a run |
| gen_x | input | M | x coordinate of the base point |
| curve_c | input | M | Curve constant, square root of the b coefficient |
| alu_done | input | 1 | ALU result valid strobe |
| alu_res | input | M | ALU result |
| alu_req | output | 1 | Request pending to the ALU |
| alu_op | output | 2 | Operation code (add, multiply, square a, square b) |
| alu_dst | output | 3 | Physical destination register code |
| alu_a | output | M | x-bus operand |
| alu_b | output | M | z-bus operand |
| x_out | output | M | Projective x of point A |
| z_out | output | M | Projective z of point A |
| done | output | 1 | Multiplication finished |

## Verification
A reference ladder computed in the bench predicts every request: its operands, its code and its physical destination. The ALU model answers with latencies from one to three cycles. Because of that varying latency, a design that samples a request before it is stable, or writes before done, shows up as a wrong operand further down the stream. The keys 0, 1, 2, all ones, a single top bit and alternating bits exercise the swap logic. A design that ignores the key bit, swaps the constants or the scratch register, or reads the bits in the wrong order produces a mismatched destination or operand. Closed-form checks on k of 0, 1 and 2 catch a wrong initial state. A start pulse injected mid-run catches a sequencer that restarts. Repeated runs catch a key index that is not reloaded.

// File: rtl/ml_pkg.sv
// Shared encodings for the ladder sequencer: ALU op codes, register select
// codes, the microinstruction layout and the fixed microprogram.
// Assumes the program counter is 5 bits and the program fits in 32 words.
package ml_pkg;

    typedef enum logic [1:0] {OP_ADD = 2'd0, OP_MUL = 2'd1, OP_SQA = 2'd2, OP_SQB = 2'd3} alu_op_e;
    typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_FIN = 2'd2} seq_st_e;

    // x-bus sources: bit1 set marks a constant that is never swapped
    localparam logic [1:0] XS_A = 2'd0, XS_B = 2'd1, XS_C = 2'd2, XS_G = 2'd3;
    // z-bus sources: scratch register is never swapped
    localparam logic [1:0] ZS_A = 2'd0, ZS_B = 2'd1, ZS_S = 2'd2;
    // destinations: codes below 4 belong to a ladder point and can swap
    localparam logic [2:0] D_XA = 3'd0, D_XB = 3'd1, D_ZA = 3'd2, D_ZB = 3'd3, D_S = 3'd4;
    localparam logic [2:0] CT_NEXT = 3'd0, CT_LOOP = 3'd1;

    localparam int          PC_W    = 5;
    localparam logic [4:0]  PC_LOOP = 5'd5;    // first addition word
    localparam logic [4:0]  PC_LAST = 5'd17;   // last doubling word

    // 12-bit microinstruction
    typedef struct packed {
        logic [1:0] xs;
        logic [1:0] zs;
        alu_op_e    op;
        logic [2:0] dst;
        logic [2:0] ctl;
    } uword_t;

    function automatic uword_t mk(logic [1:0] xs, logic [1:0] zs, alu_op_e op,
                                  logic [2:0] dst, logic [2:0] ctl);
        uword_t w;
        w.xs = xs; w.zs = zs; w.op = op; w.dst = dst; w.ctl = ctl;
        return w;
    endfunction

    // Microprogram: init, addition (B <- A+B), doubling (A <- 2A)
    function automatic uword_t ucode(logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return mk(XS_G, ZS_A, OP_SQA, D_XB, CT_NEXT);
            5'd1:  return mk(XS_G, ZS_A, OP_SQA, D_ZB, CT_NEXT);
            5'd2:  return mk(XS_B, ZS_B, OP_ADD, D_ZA, CT_NEXT);
            5'd3:  return mk(XS_G, ZS_A, OP_ADD, D_ZB, CT_NEXT);
            5'd4:  return mk(XS_G, ZS_A, OP_SQA, D_XA, CT_NEXT);
            5'd5:  return mk(XS_B, ZS_A, OP_MUL, D_XB, CT_NEXT);
            5'd6:  return mk(XS_A, ZS_B, OP_MUL, D_ZB, CT_NEXT);
            5'd7:  return mk(XS_B, ZS_B, OP_ADD, D_S,  CT_NEXT);
            5'd8:  return mk(XS_B, ZS_B, OP_MUL, D_XB, CT_NEXT);
            5'd9:  return mk(XS_A, ZS_S, OP_SQB, D_ZB, CT_NEXT);
            5'd10: return mk(XS_G, ZS_B, OP_MUL, D_S,  CT_NEXT);
            5'd11: return mk(XS_B, ZS_S, OP_ADD, D_XB, CT_NEXT);
            5'd12: return mk(XS_A, ZS_A, OP_SQA, D_XA, CT_NEXT);
            5'd13: return mk(XS_A, ZS_A, OP_SQB, D_ZA, CT_NEXT);
            5'd14: return mk(XS_C, ZS_A, OP_MUL, D_S,  CT_NEXT);
            5'd15: return mk(XS_A, ZS_A, OP_MUL, D_ZA, CT_NEXT);
            5'd16: return mk(XS_A, ZS_S, OP_ADD, D_XA, CT_NEXT);
            5'd17: return mk(XS_A, ZS_A, OP_SQA, D_XA, CT_LOOP);
            default: return mk(XS_A, ZS_A, OP_ADD, D_S, CT_NEXT);
        endcase
    endfunction

endpackage

// File: rtl/ml_ucode_rom.sv
// Microprogram store: maps the program counter to its microinstruction.
// Assumes the program is purely combinational (no wait states).
module ml_ucode_rom
    import ml_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    output uword_t          word
);
    // Decode the current word from the fixed program
    always_comb word = ucode(pc);
endmodule

// File: rtl/ml_key_ctrl.sv
// Key index counter and bit multiplexer. Loads M-1 on reset or load,
// counts down on dec, and presents the selected key bit.
// Assumes key is stable for the whole run and M >= 2.
module ml_key_ctrl #(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [M-1:0] key,
    output logic         key_bit,
    output logic         idx_zero
);
    localparam int IW = (M > 1) ? $clog2(M) : 1;
    localparam logic [IW-1:0] TOP = IW'(M - 1);

    logic [IW-1:0] idx;

    // Bit index: reload to the top on start, step down at loop end
    always_ff @(posedge clk) begin
        if (!rst_n || load) idx <= TOP;
        else if (dec)       idx <= idx - 1'b1;
    end

    // Pick the current key bit and flag the last iteration
    always_comb begin
        key_bit  = key[idx];
        idx_zero = (idx == '0);
    end
endmodule

// File: rtl/ml_regfile.sv
// Ladder working registers with swap-aware bus multiplexers. The swap
// input exchanges A and B roles on both operand selects and destination.
// Assumes logical codes from ml_pkg; constants and scratch never swap.
module ml_regfile
    import ml_pkg::*;
#(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         swap,
    input  logic [1:0]   xs,
    input  logic [1:0]   zs,
    input  logic [2:0]   dst,
    input  logic         we,
    input  logic [M-1:0] wdata,
    input  logic [M-1:0] gen_x,
    input  logic [M-1:0] curve_c,
    output logic [M-1:0] xbus,
    output logic [M-1:0] zbus,
    output logic [2:0]   dst_p,
    output logic [M-1:0] xa,
    output logic [M-1:0] za
);
    localparam int NREG = 5;

    logic [M-1:0] r [NREG];
    logic [1:0]   xs_p, zs_p;

    // Apply the key swap to selects that name a ladder point
    always_comb begin
        xs_p  = xs[1] ? xs : {xs[1], xs[0] ^ swap};
        zs_p  = (zs == ZS_S) ? zs : {zs[1], zs[0] ^ swap};
        dst_p = dst[2] ? dst : {dst[2:1], dst[0] ^ swap};
    end

    // x-bus and z-bus operand multiplexers
    always_comb begin
        case (xs_p)
            XS_A:    xbus = r[0];
            XS_B:    xbus = r[1];
            XS_C:    xbus = curve_c;
            default: xbus = gen_x;
        endcase
        case (zs_p)
            ZS_A:    zbus = r[2];
            ZS_B:    zbus = r[3];
            default: zbus = r[4];
        endcase
    end

    // Register write: only the named destination takes the result
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)                      r[i] <= '0;
            else if (we && dst_p == 3'(i))   r[i] <= wdata;
        end
    end

    // Point A is the block result
    always_comb begin
        xa = r[0];
        za = r[2];
    end
endmodule

// File: rtl/ml_ladder_seq.sv
// Montgomery ladder sequencer top. Steps a fixed microprogram, issues one
// ALU request at a time and writes the result on alu_done. The key bit
// only steers register roles. Assumes key, gen_x and curve_c are stable
// during a run and the ALU answers every request.
module ml_ladder_seq
    import ml_pkg::*;
#(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] key,
    input  logic [M-1:0] gen_x,
    input  logic [M-1:0] curve_c,
    input  logic         alu_done,
    input  logic [M-1:0] alu_res,
    output logic         alu_req,
    output logic [1:0]   alu_op,
    output logic [2:0]   alu_dst,
    output logic [M-1:0] alu_a,
    output logic [M-1:0] alu_b,
    output logic [M-1:0] x_out,
    output logic [M-1:0] z_out,
    output logic         done
);
    seq_st_e          st;
    logic [PC_W-1:0]  pc;
    uword_t           word;
    logic             key_bit, idx_zero, swap;
    logic             accept, we, at_loop, key_dec;

    ml_ucode_rom rom_i (.pc(pc), .word(word));

    // Control strobes derived from state and handshake
    always_comb begin
        accept  = (st != S_RUN) && start;
        we      = (st == S_RUN) && alu_done;
        at_loop = (word.ctl == CT_LOOP);
        key_dec = we && at_loop && !idx_zero;
        swap    = (pc >= PC_LOOP) && key_bit;
    end

    ml_key_ctrl #(.M(M)) key_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .dec(key_dec),
        .key(key), .key_bit(key_bit), .idx_zero(idx_zero)
    );

    ml_regfile #(.M(M)) rf_i (
        .clk(clk), .rst_n(rst_n), .swap(swap),
        .xs(word.xs), .zs(word.zs), .dst(word.dst),
        .we(we), .wdata(alu_res), .gen_x(gen_x), .curve_c(curve_c),
        .xbus(alu_a), .zbus(alu_b), .dst_p(alu_dst),
        .xa(x_out), .za(z_out)
    );

    // Sequencer: start, advance per completed request, loop per key bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
            pc <= '0;
        end else if (accept) begin
            st <= S_RUN;
            pc <= '0;
        end else if (we) begin
            if (!at_loop)      pc <= pc + 1'b1;
            else if (idx_zero) st <= S_FIN;
            else               pc <= PC_LOOP;
        end
    end

    // Request and completion outputs
    always_comb begin
        alu_req = (st == S_RUN);
        alu_op  = word.op;
        done    = (st == S_FIN);
    end
endmodule

// File: rtl/ml_ladder_chk.sv
// Protocol checker for ml_ladder_seq, attached by bind.
module ml_ladder_chk #(
    parameter int M = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         alu_req,
    input logic         alu_done,
    input logic [1:0]   alu_op,
    input logic [2:0]   alu_dst,
    input logic [M-1:0] alu_a,
    input logic [M-1:0] alu_b,
    input logic [M-1:0] x_out,
    input logic [M-1:0] z_out,
    input logic         done
);
    // R1: quiet right after reset release
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!alu_req && !done));

    // R7: pending request holds its fields until done
    a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req && !alu_done) |=> (alu_req && $stable(alu_a) && $stable(alu_b)
                                    && $stable(alu_op) && $stable(alu_dst)));

    // R8: finished state holds without start
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(x_out) && $stable(z_out)));

    // R8: no request once finished
    a_r8_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !alu_req);

    // R6: destination is always one of the five registers
    a_r6_dst_legal: assert property (@(posedge clk) disable iff (!rst_n)
        alu_req |-> (alu_dst <= 3'd4));
endmodule

bind ml_ladder_seq ml_ladder_chk #(.M(M)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .alu_req(alu_req),
    .alu_done(alu_done), .alu_op(alu_op), .alu_dst(alu_dst),
    .alu_a(alu_a), .alu_b(alu_b), .x_out(x_out), .z_out(z_out), .done(done)
);

// File: tb/ml_ladder_seq_tb_top.sv
// Scoreboard bench: a reference ladder pushes expected requests into a
// queue; the ALU model pops and compares each request it accepts.
module ml_ladder_seq_tb_top;
    localparam int M = 8;
    localparam logic [M-1:0] POLY_LO = 8'h1B;   // x^8+x^4+x^3+x+1
    localparam int CLK_PERIOD = 10;
    localparam int QW = 5 + 2 * M;

    logic clk = 0, rst_n = 0, start = 0;
    logic [M-1:0] key = '0, gen_x = '0, curve_c = '0;
    logic alu_done = 0;
    logic [M-1:0] alu_res = '0;
    logic alu_req, done;
    logic [1:0] alu_op;
    logic [2:0] alu_dst;
    logic [M-1:0] alu_a, alu_b, x_out, z_out;

    int checks = 0, fails = 0, nreq = 0;
    logic [QW-1:0] exp_q[$];
    logic [M-1:0] rr [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    ml_ladder_seq #(.M(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .gen_x(gen_x),
        .curve_c(curve_c), .alu_done(alu_done), .alu_res(alu_res),
        .alu_req(alu_req), .alu_op(alu_op), .alu_dst(alu_dst),
        .alu_a(alu_a), .alu_b(alu_b), .x_out(x_out), .z_out(z_out), .done(done)
    );

    function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
        logic [M-1:0] r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY_LO : '0);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Reference step: codes per R2, R3, R4; swap per R6
    task automatic ref_op(input int op, input int xs, input int zs, input int dst, input bit sw);
        int xp, zp, dp;
        logic [M-1:0] a, b, res;
        xp = (xs >= 2) ? xs : (xs ^ int'(sw));
        zp = (zs == 2) ? zs : (zs ^ int'(sw));
        dp = (dst >= 4) ? dst : (dst ^ int'(sw));
        case (xp) 0: a = rr[0]; 1: a = rr[1]; 2: a = curve_c; default: a = gen_x; endcase
        b = rr[zp + 2];
        case (op) 0: res = a ^ b; 1: res = gmul(a, b); 2: res = gmul(a, a); default: res = gmul(b, b); endcase
        exp_q.push_back({2'(op), 3'(dp), a, b});
        rr[dp] = res;
    endtask

    // Driver: full reference run, MSB-first key (R5)
    task automatic ref_run(input logic [M-1:0] k);
        ref_op(2, 3, 0, 1, 0); ref_op(2, 3, 0, 3, 0);
        ref_op(0, 1, 1, 2, 0); ref_op(0, 3, 0, 3, 0); ref_op(2, 3, 0, 0, 0);
        for (int i = M - 1; i >= 0; i--) begin
            bit sw = k[i];
            ref_op(1, 1, 0, 1, sw); ref_op(1, 0, 1, 3, sw); ref_op(0, 1, 1, 4, sw);
            ref_op(1, 1, 1, 1, sw); ref_op(3, 0, 2, 3, sw); ref_op(1, 3, 1, 4, sw);
            ref_op(0, 1, 2, 1, sw);
            ref_op(2, 0, 0, 0, sw); ref_op(3, 0, 0, 2, sw); ref_op(1, 2, 0, 4, sw);
            ref_op(1, 0, 0, 2, sw); ref_op(0, 0, 2, 0, sw); ref_op(2, 0, 0, 0, sw);
        end
    endtask

    // ALU model and monitor: accepts at negedge, answers after 1..3 cycles.
    // Each accepted request is compared against the queue (R2 R3 R4 R6 R7).
    bit busy = 0;
    int cnt = 0, lat_seed = 0;
    logic [M-1:0] res_hold;
    always @(negedge clk) begin
        if (alu_done) begin alu_done = 0; busy = 0; end
        if (!rst_n) busy = 0;
        else if (busy) begin
            if (cnt == 1) begin alu_res = res_hold; alu_done = 1; end
            else cnt--;
        end else if (alu_req) begin
            logic [QW-1:0] got, exp;
            got = {alu_op, alu_dst, alu_a, alu_b};
            nreq++;
            if (exp_q.size() == 0) chk(0, "R5 extra request", 64'(got), 64'(0));
            else begin
                exp = exp_q.pop_front();
                chk(got == exp, "R6 request stream", 64'(got), 64'(exp));
            end
            case (alu_op)
                2'd0: res_hold = alu_a ^ alu_b;
                2'd1: res_hold = gmul(alu_a, alu_b);
                2'd2: res_hold = gmul(alu_a, alu_a);
                default: res_hold = gmul(alu_b, alu_b);
            endcase
            lat_seed++;
            cnt = 1 + (lat_seed % 3);
            busy = 1;
        end
    end

    task automatic do_run(input logic [M-1:0] k, input logic [M-1:0] g, input logic [M-1:0] c, input bit poke);
        int cyc = 0;
        logic [M-1:0] hx, hz;
        key = k; gen_x = g; curve_c = c; nreq = 0;
        ref_run(k);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk); cyc++;
            start = poke && (cyc == 40);   // R10 injected start
        end
        start = 0;
        chk(done == 1'b1, "R8 done raised", 64'(done), 64'(1));
        chk(alu_req == 1'b0, "R8 no request when done", 64'(alu_req), 64'(0));
        chk(nreq == 5 + 13 * M && exp_q.size() == 0, "R5 request count", 64'(nreq), 64'(5 + 13 * M));
        chk(x_out == rr[0], "R9 x_out", 64'(x_out), 64'(rr[0]));
        chk(z_out == rr[2], "R9 z_out", 64'(z_out), 64'(rr[2]));
        exp_q.delete();
        hx = x_out; hz = z_out;
        repeat (3) @(negedge clk);
        chk(done && x_out == hx && z_out == hz, "R8 hold", 64'({x_out, z_out}), 64'({hx, hz}));
    endtask

    initial begin
        repeat (1_500_000 / CLK_PERIOD) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [M-1:0] g2;
        for (int i = 0; i < 5; i++) rr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!alu_req && !done && x_out == 0 && z_out == 0, "R1 reset state",
            64'({alu_req, done, x_out, z_out}), 64'(0));

        do_run(8'h00, 8'h57, 8'h2D, 0);
        chk(z_out == 0, "R9 k=0 infinity", 64'(z_out), 64'(0));

        do_run(8'h01, 8'h57, 8'h2D, 0);     // R11 restart from done
        chk(z_out != 0 && x_out == gmul(gen_x, z_out), "R9 k=1 ratio",
            64'(x_out), 64'(gmul(gen_x, z_out)));

        do_run(8'h02, 8'h3A, 8'h91, 0);
        g2 = gmul(gen_x, gen_x);
        chk(gmul(x_out, g2) == gmul(z_out, gmul(g2, g2) ^ gmul(curve_c, curve_c)),
            "R9 k=2 doubling", 64'(gmul(x_out, g2)),
            64'(gmul(z_out, gmul(g2, g2) ^ gmul(curve_c, curve_c))));

        do_run(8'hFF, 8'h1C, 8'h66, 0);     // R6 swap on every bit
        do_run(8'h80, 8'hC3, 8'h05, 0);     // R5 top bit only
        do_run(8'hA5, 8'h6E, 8'hB2, 1);     // R10 start mid-run
        do_run(8'h5A, 8'h6E, 8'hB2, 0);     // R3 R4 alternating bits

        summary();
        $finish;
    end
endmodule